// File: doc/BRIEF.md
# Pin control register bank

This block holds the control state for the 32 pins of one port, behind a simple 32-bit register bus. Each pin has one control word at offset 4*n. It holds a 16-bit configuration field, a 4-bit interrupt detect mode and a sticky interrupt flag. Two broadcast registers let software write one 16-bit value into many pin words with a single bus write. The low broadcast register serves pins 0..15 and the high one serves pins 16..31. A broadcast write skips any pin word that is locked.

Each pin receives a one-cycle detect strobe from detection logic outside this block. The strobe sets the pin's flag. The flag can be read and cleared in two places: in the pin's own control word, and in a 32-bit write-one-to-clear status register. A single registered interrupt line is raised while any flag is set on a pin whose detect mode is non-zero. Reads are combinational on the current address. Writes take effect at the clock edge on which `bus_wr_en` is high.

Map (word offsets): pin n at 0x00 + 4*n. Broadcast low at 0x80. Broadcast high at 0x84. Status at 0xA0. Any other address reads zero.

Pin word layout:
- Bits 15:0 hold the configuration field. Bit 15 is the lock bit.
- Bits 19:16 hold the detect mode.
- Bit 24 holds the flag.
- All other bits read zero.

Top module: `pin_ctrl_bank`

## Requirements
- R1: After reset, every pin word, both broadcast registers and the status register read 0, and `irq` is 0.
- R2: A write to pin word n updates bits 7:0 when strobe bit 0 is set and bits 15:8 when strobe bit 1 is set. It updates the detect mode (bits 19:16) when strobe bit 2 is set. Each change is visible on a read in the cycle after the write edge.
- R3: Writing bit 15 of a pin word as 1 locks it, and the lock holds until reset. While a word is locked, any write to its bits 15:0 has no effect. Its detect mode stays writable.
- R4: A full-width write to 0x80 copies data bits 15:0 into bits 15:0 of each pin word k (0..15) whose enable bit 16+k is 1. Pin words whose enable bit is 0 keep their value.
- R5: A full-width write to 0x84 copies data bits 15:0 into bits 15:0 of each pin word 16+k (k = 0..15) whose enable bit 16+k is 1. Pin words whose enable bit is 0 keep their value.
- R6: A broadcast write leaves a locked pin word unchanged, even when that word is selected.
- R7: A broadcast write has an effect only when all four byte strobes are set (4'hF). With any other strobe value it changes nothing. Both broadcast registers always read as 0.
- R8: A detect strobe on pin n sets flag n at the next edge, and the flag stays set until it is cleared. Flag n reads back as bit n of the status register (0xA0) and as bit 24 of pin word n.
- R9: A flag is cleared in either of two ways. One is writing 1 to its status bit, with that bit's byte strobe set. The other is writing 1 to bit 24 of its pin word, with strobe bit 3 set. Both ways work while the word is locked. Writing 0 to a flag has no effect.
- R10: If a detect strobe and a clear reach the same flag in the same cycle, the flag ends up set.
- R11: `irq` is a register. Its value in each cycle is the OR, over the previous cycle, of every flag whose pin has a non-zero detect mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Write request for this cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr_strb | input | 4 | Byte lane enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| det_strobe | input | 32 | Per-pin detect pulses that set the flags |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench goes after the points where the lock meets other writers. It broadcasts across a locked word, rewrites a locked word, and clears a locked word's flag. A design that checked the lock in only one write path would corrupt the locked value, or would refuse a clear it should accept. It sends partial-strobe writes to the broadcast registers. A design that did not check strobes would change many pin words at once. It sends a strobe and a clear to the same flag in the same cycle. A design where clear has priority would lose the event. It also clears flags from both locations while watching `irq`. A design that fed the interrupt from only one copy of the flag, or from pins in mode 0, would hold the line high or fail to raise it.

// File: rtl/pin_ctrl_bank.sv
module pin_ctrl_bank #(
  parameter int NPIN = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr_en,
  input  logic [AW-1:0]   bus_addr,
  input  logic [3:0]      bus_wr_strb,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NPIN-1:0] det_strobe,
  output logic            irq
);
  localparam int IW    = AW - 2;
  localparam int HALF  = NPIN / 2;
  localparam int LOCKB = 15;
  localparam logic [IW-1:0] BC_LO = IW'(8'h80 >> 2);
  localparam logic [IW-1:0] BC_HI = IW'(8'h84 >> 2);
  localparam logic [IW-1:0] STAT  = IW'(8'hA0 >> 2);

  logic [15:0]     ctrl_q [NPIN];
  logic [3:0]      mode_q [NPIN];
  logic [NPIN-1:0] flag_q, clr_vec, en_vec;

  wire [IW-1:0] idx     = bus_addr[AW-1:2];
  wire          pin_hit = (32'(idx) < NPIN);
  wire          full_wr = bus_wr_en && (bus_wr_strb == 4'hF);
  wire          bc_lo   = full_wr && (idx == BC_LO);
  wire          bc_hi   = full_wr && (idx == BC_HI);
  wire          st_wr   = bus_wr_en && (idx == STAT);

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    wire grp  = (g < HALF) ? bc_lo : bc_hi;
    wire bsel = grp && bus_wdata[16 + (g % HALF)];
    wire psel = bus_wr_en && pin_hit && (32'(idx) == g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[g] <= '0;
        mode_q[g] <= '0;
      end else begin
        if (!ctrl_q[g][LOCKB]) begin
          if (bsel) ctrl_q[g] <= bus_wdata[15:0];
          else if (psel) begin
            if (bus_wr_strb[0]) ctrl_q[g][7:0]  <= bus_wdata[7:0];
            if (bus_wr_strb[1]) ctrl_q[g][15:8] <= bus_wdata[15:8];
          end
        end
        if (psel && bus_wr_strb[2]) mode_q[g] <= bus_wdata[19:16];
      end
    end

    assign clr_vec[g] = (st_wr && bus_wr_strb[g / 8] && bus_wdata[g])
                      || (psel && bus_wr_strb[3] && bus_wdata[24]);
    assign en_vec[g]  = |mode_q[g];

    a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[g][LOCKB] |=> $stable(ctrl_q[g]));
    a_r7_partial_bcast_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && (idx == BC_LO || idx == BC_HI) && bus_wr_strb != 4'hF)
      |=> $stable(ctrl_q[g]));
    a_r8_flag_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[g]) |-> $past(det_strobe[g]));
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      det_strobe[g] |=> flag_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      irq    <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~clr_vec) | det_strobe;
      irq    <= |(flag_q & en_vec);
    end
  end

  a_r11_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_q & en_vec)) |=> irq);

  always_comb begin
    bus_rdata = '0;
    if (pin_hit)
      bus_rdata = {7'b0, flag_q[32'(idx)], 4'b0, mode_q[32'(idx)], ctrl_q[32'(idx)]};
    else if (idx == STAT)
      bus_rdata = 32'(flag_q);
  end
endmodule

// File: tb/pin_ctrl_bank_tb.sv
module pin_ctrl_bank_tb_top;
  logic clk = 0, rst_n = 0, wr = 0;
  logic [7:0] addr = 0;
  logic [3:0] strb = 0;
  logic [31:0] wdata = 0, det = 0, rdata;
  logic irq;

  always #10 clk = ~clk;

  pin_ctrl_bank dut_i (.clk(clk), .rst_n(rst_n), .bus_wr_en(wr), .bus_addr(addr),
    .bus_wr_strb(strb), .bus_wdata(wdata), .bus_rdata(rdata), .det_strobe(det), .irq(irq));

  logic [15:0] m_ctrl [32];
  logic [3:0]  m_mode [32];
  logic [31:0] m_flag;
  logic        m_irq;
  int nchk = 0, nfail = 0;
  bit done = 0;
  string cur = "R1";

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int i = int'(a[7:2]);
    if (i < 32) return {7'b0, m_flag[i], 4'b0, m_mode[i], m_ctrl[i]};
    if (a[7:2] == 6'h28) return m_flag;
    return 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, got, exp);
    end
  endtask

  task automatic cyc(input bit w, input logic [7:0] a, input logic [3:0] s,
                     input logic [31:0] d, input logic [31:0] dt);
    logic [31:0] clr, en;
    int i;
    wr = w; addr = a; strb = s; wdata = d; det = dt;
    #1;
    chk(cur, rdata, m_read(a));
    chk({cur, "/R11 irq"}, 32'(irq), 32'(m_irq));
    @(posedge clk);
    clr = 0; en = 0;
    for (int k = 0; k < 32; k++) en[k] = (m_mode[k] != 0);
    i = int'(a[7:2]);
    if (w) begin
      if (a[7:2] == 6'h28)
        for (int k = 0; k < 32; k++) if (s[k/8] && d[k]) clr[k] = 1;
      if (i < 32) begin
        if (s[3] && d[24]) clr[i] = 1;
        if (!m_ctrl[i][15]) begin
          if (s[0]) m_ctrl[i][7:0] = d[7:0];
          if (s[1]) m_ctrl[i][15:8] = d[15:8];
        end
        if (s[2]) m_mode[i] = d[19:16];
      end
      if (s == 4'hF && (a[7:2] == 6'h20 || a[7:2] == 6'h21))
        for (int k = 0; k < 16; k++) begin
          int p = (a[7:2] == 6'h20) ? k : 16 + k;
          if (d[16+k] && !m_ctrl[p][15]) m_ctrl[p] = d[15:0];
        end
    end
    m_irq = |(m_flag & en);
    m_flag = (m_flag & ~clr) | dt;
    @(negedge clk);
  endtask

  task automatic wrt(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    cyc(1, a, s, d, 0);
  endtask
  task automatic rd(input logic [7:0] a);
    cyc(0, a, 0, 0, 0);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 32; k++) begin m_ctrl[k] = 0; m_mode[k] = 0; end
    m_flag = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur = "R1";
    rd(8'h00); rd(8'h7C); rd(8'h80); rd(8'h84); rd(8'hA0);
    chk("R1 irq", 32'(irq), 0);
    cur = "R2";
    wrt(8'h0C, 32'h0005_1234); rd(8'h0C);
    wrt(8'h0C, 32'hFFFF_FFAB, 4'b0001); rd(8'h0C);
    chk("R2 pin3", rdata, 32'h0005_12AB);
    wrt(8'h50, 32'h0003_0000, 4'b0100); rd(8'h50);
    cur = "R4";
    wrt(8'h80, 32'h0005_5A5A); rd(8'h00); rd(8'h04); rd(8'h08);
    chk("R4 pin2", rdata, 32'h0000_5A5A);
    cur = "R5";
    wrt(8'h84, 32'h8001_0F0F); rd(8'h40); rd(8'h44); rd(8'h7C);
    chk("R5 pin31", rdata, 32'h0000_0F0F);
    cur = "R3";
    wrt(8'h14, 32'h0001_8000); wrt(8'h14, 32'h0002_1111); rd(8'h14);
    chk("R3 locked pin5", rdata, 32'h0002_8000);
    cur = "R6";
    wrt(8'h80, 32'hFFFF_0202); rd(8'h14); rd(8'h18);
    chk("R6 pin6", rdata, 32'h0000_0202);
    cur = "R7";
    wrt(8'h84, 32'hFFFF_1357, 4'b0011); wrt(8'h80, 32'hFFFF_2468, 4'b0111);
    rd(8'h40); rd(8'h00); rd(8'h84); rd(8'h80);
    cur = "R8";
    cyc(0, 8'hA0, 0, 0, 32'h4000_0008); rd(8'hA0); rd(8'h0C); rd(8'h78);
    chk("R8 status", m_read(8'hA0), 32'h4000_0008);
    cur = "R11";
    rd(8'h00); chk("R11 irq high", 32'(irq), 1);
    cur = "R9";
    wrt(8'hA0, 32'h0000_0008, 4'b0001); wrt(8'h78, 32'h0100_0000, 4'b1000);
    rd(8'hA0); rd(8'hA0); chk("R9 cleared", rdata, 0);
    cyc(0, 8'h14, 0, 0, 32'h0000_0020); wrt(8'h14, 32'h0100_0000, 4'b1000);
    rd(8'h14); chk("R9 locked clear", rdata, 32'h0002_8000);
    wrt(8'hA0, 32'h0000_0000); rd(8'hA0);
    cur = "R10";
    cyc(1, 8'hA0, 4'hF, 32'h0000_0080, 32'h0000_0080); rd(8'hA0);
    chk("R10 set wins", rdata, 32'h0000_0080);
    cur = "R9 mixed";
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r = $urandom;
      logic [7:0] a;
      case (r[1:0])
        2'd0: a = 8'h80;
        2'd1: a = 8'h84;
        2'd2: a = 8'hA0;
        default: a = {1'b0, r[6:2], 2'b00};
      endcase
      if (r[9:2] == 8'h00) a = 8'h80 | {r[13:10], 2'b00};
      cyc(r[10], a, r[15:12], {$urandom} & ((a < 8'h80) ? 32'hFFFF_7FFF | {16'h0, r[16] & r[17] & r[18], 15'h0} : 32'hFFFF_FFFF),
          ($urandom % 4 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule